// File: doc/BRIEF.md
# Parity-guarded register bank

This block is a bank of single-bit state registers with soft-error detection built around the flops themselves. The first part of the bank is protected and is split into groups. Each group has one extra parity flop. On every clock edge that flop captures the XOR of the next-state values that the group's registers capture on the same edge. In the following cycle the XOR of the group's current register outputs is compared with that stored bit. If an upset changes a register's content after its next-state value was formed, the two values disagree and the alarm output rises.

Each register loads its data bit when its write enable bit is set and keeps its value otherwise. Registers above the protected count have no parity coverage. A test-only flip input corrupts one selected register as it captures, while the parity flop still records the correct value. The bench uses this to confirm that an upset is detected. Parameters set the total register count, the protected count and the group size. When the group size does not divide the protected count evenly, the last group is smaller.

Top module: `pgrb_top`

## Requirements
- R1: While rst_ni is low, every data register and every parity flop is zero, so q_o reads all zeros and alarm_o is low.
- R2: On each rising clock edge, register i loads d_i[i] when we_i[i] is 1 and otherwise holds its value.
- R3: Each group's parity flop captures the XOR of its registers' next-state values on the same edge as the registers. Under any pattern of writes without an upset, alarm_o stays low.
- R4: alarm_o is combinational from the register outputs and the stored parity. After an upset of a protected register at an edge, alarm_o is high until the next edge. If no further upset occurs, it is low again after that edge.
- R5: Registers with index at or above NUM_PROT are never covered, so an upset in them never raises alarm_o.
- R6: Group g covers registers g*GROUP_SZ up to min((g+1)*GROUP_SZ, NUM_PROT)-1. The last group holds the remainder, and an upset in its highest register is detected.
- R7: When flip_en_i is 1 at an edge, register flip_sel_i stores the inverse of its next-state value. A flip_sel_i value of NUM_REGS or above changes nothing.
- R8: alarm_o is the OR of all group mismatches, so an upset in any single group raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d_i | input | NUM_REGS | Data bit for each register |
| we_i | input | NUM_REGS | Write enable for each register |
| flip_en_i | input | 1 | Test upset enable |
| flip_sel_i | input | SEL_W | Index of the register to upset |
| q_o | output | NUM_REGS | Register contents |
| alarm_o | output | 1 | Error detected in any protected group |

## Verification
The bench injects an upset into the first and last register of every group, including the short remainder group. A wrong group boundary would either miss the last protected register or flag an unprotected one. It also upsets registers that are being written in the same cycle, to catch parity taken from the outputs instead of the next-state values. Such a design would alarm on ordinary writes or miss these upsets. Alarms must last exactly one cycle, so a checker that latched the alarm or compared against stale parity shows up as a stuck or late alarm. Out-of-range flip selects and unprotected upsets must leave alarm_o low, and they must change q_o only as stated.

// File: rtl/pgrb_pkg.sv
package pgrb_pkg;
  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) + 1 : 1;
  endfunction

  function automatic int unsigned grp_count(input int unsigned prot, input int unsigned gsz);
    return (prot + gsz - 1) / gsz;
  endfunction

  function automatic int unsigned grp_hi(input int unsigned g, input int unsigned prot,
                                         input int unsigned gsz);
    int unsigned top;
    top = (g + 1) * gsz;
    if (top > prot) top = prot;
    return top - 1;
  endfunction
endpackage

// File: rtl/pgrb_flip_dec.sv
module pgrb_flip_dec #(
  parameter int unsigned NUM_REGS = 12,
  parameter int unsigned SEL_W    = 5
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NUM_REGS-1:0] mask_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign mask_o[i] = en_i && (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/pgrb_store.sv
module pgrb_store #(
  parameter int unsigned NUM_REGS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] d_i,
  input  logic [NUM_REGS-1:0] we_i,
  input  logic [NUM_REGS-1:0] flip_i,
  output logic [NUM_REGS-1:0] nxt_o,
  output logic [NUM_REGS-1:0] q_o
);
  logic [NUM_REGS-1:0] q_q;

  assign nxt_o = (we_i & d_i) | (~we_i & q_q);

  // flip models an upset: the flop captures a value the parity never saw
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt_o ^ flip_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pgrb_group_parity.sv
module pgrb_group_parity #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] nxt_i,
  input  logic [N-1:0] q_i,
  output logic         mismatch_o
);
  logic par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= 1'b0;
    else         par_q <= ^nxt_i;
  end

  assign mismatch_o = par_q ^ (^q_i);
endmodule

// File: rtl/pgrb_top.sv
module pgrb_top
  import pgrb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12,
  parameter int unsigned NUM_PROT = 10,
  parameter int unsigned GROUP_SZ = 4,
  parameter int unsigned SEL_W    = sel_width(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] d_i,
  input  logic [NUM_REGS-1:0] we_i,
  input  logic                flip_en_i,
  input  logic [SEL_W-1:0]    flip_sel_i,
  output logic [NUM_REGS-1:0] q_o,
  output logic                alarm_o
);
  localparam int unsigned NUM_GROUPS = grp_count(NUM_PROT, GROUP_SZ);

  logic [NUM_REGS-1:0]   flip_mask;
  logic [NUM_REGS-1:0]   nxt;
  logic [NUM_REGS-1:0]   q;
  logic [NUM_GROUPS-1:0] grp_err;

  pgrb_flip_dec #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_dec (
    .en_i  (flip_en_i),
    .sel_i (flip_sel_i),
    .mask_o(flip_mask)
  );

  pgrb_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .we_i  (we_i),
    .flip_i(flip_mask),
    .nxt_o (nxt),
    .q_o   (q)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = g * GROUP_SZ;
    localparam int unsigned HI = grp_hi(g, NUM_PROT, GROUP_SZ);
    pgrb_group_parity #(.N(HI - LO + 1)) u_par (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .nxt_i     (nxt[HI:LO]),
      .q_i       (q[HI:LO]),
      .mismatch_o(grp_err[g])
    );
  end

  assign q_o     = q;
  assign alarm_o = |grp_err;
endmodule

// File: rtl/pgrb_checker.sv
module pgrb_checker #(
  parameter int unsigned NUM_REGS = 12,
  parameter int unsigned NUM_PROT = 10,
  parameter int unsigned SEL_W    = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_REGS-1:0] d_i,
  input logic [NUM_REGS-1:0] we_i,
  input logic                flip_en_i,
  input logic [SEL_W-1:0]    flip_sel_i,
  input logic [NUM_REGS-1:0] q_o,
  input logic                alarm_o
);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && !alarm_o));

  a_r2_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flip_en_i |=> q_o == (($past(we_i) & $past(d_i)) | (~$past(we_i) & $past(q_o))));

  a_r3_no_false_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flip_en_i |=> !alarm_o);

  a_r4_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_en_i && flip_sel_i < SEL_W'(NUM_PROT)) |=> alarm_o);

  a_r5_unprotected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_en_i && flip_sel_i >= SEL_W'(NUM_PROT)) |=> !alarm_o);

  a_r7_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_en_i && flip_sel_i < SEL_W'(NUM_REGS)) |=>
      $countones(q_o ^ (($past(we_i) & $past(d_i)) | (~$past(we_i) & $past(q_o)))) == 1);
endmodule

bind pgrb_top pgrb_checker #(
  .NUM_REGS(NUM_REGS), .NUM_PROT(NUM_PROT), .SEL_W(SEL_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .d_i       (d_i),
  .we_i      (we_i),
  .flip_en_i (flip_en_i),
  .flip_sel_i(flip_sel_i),
  .q_o       (q_o),
  .alarm_o   (alarm_o)
);

// File: tb/tb_pgrb_top.sv
`timescale 1ns/1ps
module tb_pgrb_top;
  localparam int unsigned NR = 12;
  localparam int unsigned NP = 10;
  localparam int unsigned GS = 4;
  localparam int unsigned SW = 5;

  typedef struct {
    logic [NR-1:0] q;
    logic          alarm;
    string         tag;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NR-1:0] d_i = '0;
  logic [NR-1:0] we_i = '0;
  logic          flip_en_i = 1'b0;
  logic [SW-1:0] flip_sel_i = '0;
  logic [NR-1:0] q_o;
  logic          alarm_o;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  logic [NR-1:0] model = '0;
  logic done = 1'b0;

  always #4 clk_i = ~clk_i;

  pgrb_top #(.NUM_REGS(NR), .NUM_PROT(NP), .GROUP_SZ(GS)) dut (
    .clk_i, .rst_ni, .d_i, .we_i, .flip_en_i, .flip_sel_i, .q_o, .alarm_o
  );

  task automatic check(input string tag, input logic [NR-1:0] aq, input logic aa,
                       input logic [NR-1:0] eq, input logic ea);
    checks++;
    if (aq !== eq || aa !== ea) begin
      errors++;
      $display("FAIL %s: q=%h alarm=%b expected q=%h alarm=%b", tag, aq, aa, eq, ea);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic [NR-1:0] d, input logic [NR-1:0] we,
                      input logic fe, input int sel, input string tag);
    exp_t e;
    @(negedge clk_i);
    d_i = d; we_i = we; flip_en_i = fe; flip_sel_i = SW'(sel);
    model = (we & d) | (~we & model);
    if (fe && sel < NR) model[sel] = ~model[sel];
    e.q = model;
    e.alarm = fe && (sel < NP);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: sample 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rst_ni && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, q_o, alarm_o, e.q, e.alarm);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 reset", q_o, alarm_o, '0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(12'hA5C, 12'hFFF, 1'b0, 0, "R2 full write");
    step(12'h000, 12'h000, 1'b0, 0, "R2 hold");
    step(12'hFFF, 12'h0F0, 1'b0, 0, "R2 partial write");
    step(12'h3C3, 12'hF0F, 1'b0, 0, "R3 write no alarm");
    step(12'h000, 12'h000, 1'b0, 0, "R3 idle");
    // first and last register of every group, plus unprotected ones
    for (int s = 0; s < NR; s++) begin
      step(12'h000, 12'h000, 1'b1, s, (s < NP) ? "R4 R8 upset detect" : "R5 unprotected upset");
      step(12'h000, 12'h000, 1'b0, 0, "R4 alarm clears");
    end
    step(12'h000, 12'h000, 1'b1, 9, "R6 remainder group last reg");
    step(12'h000, 12'h000, 1'b0, 0, "R6 clear");
    step(12'hFFF, 12'h210, 1'b1, 4, "R7 upset while writing");
    step(12'h555, 12'hFFF, 1'b0, 0, "R3 write after upset");
    step(12'hAAA, 12'hFFF, 1'b1, 12, "R7 select out of range");
    step(12'h000, 12'h000, 1'b1, 31, "R7 select max out of range");
    step(12'h000, 12'h000, 1'b1, 11, "R5 last unprotected");
    step(12'h000, 12'h000, 1'b0, 0, "R3 final idle");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule